// File: doc/BRIEF.md
# Bilevel Overcurrent Fault Timer

This block holds the digital fault timing for one channel of a hot-swap power switch. Two comparator flags come in from the analog front end. One reports that the load current has reached the current-limit level. The other reports that it has reached the higher circuit-breaker level. Each flag drives its own integrating timer, and the block advances both timers on a 1 kHz millisecond strobe.

The current-limit timer charges one unit per tick while its flag is set. It then bleeds away 128 times more slowly, so a series of short overloads close together still adds up to a fault. The circuit-breaker timer charges and discharges at the same rate. When either timer reaches its programmed timeout, the block turns the gate off, fires a one-cycle fast-pulldown command and pulls its active-low fault output low. After that, a mode input decides what happens next. In latch mode the channel stays off until it is cycled through shutdown. In retry mode the channel comes back after a fixed cool-down.

Enable, undervoltage and ON qualification arrive as digital flags. The block combines them into a shutdown decision and a turn-on decision. While the channel is on, the current-limit flag is passed through as a regulate command for the analog gate loop.

Top module: `oc_fault_timer`

## Requirements
- R1: The channel is in shutdown when `en_z` is low, or when `en_x` and `en_y` are both low. One clock after shutdown is seen, `gate_en` is 0 and `fault_n` is 1, from any state, including a latched fault. A single low `en_x` or `en_y` has no effect.
- R2: The channel turns on (`gate_en` = 1) one clock after `supply_ok` and `on_ok` are both 1 and shutdown is absent. If either flag drops while the channel is on, `gate_en` falls one clock later and `fault_n` stays 1.
- R3: `reg_cmd` equals `lim_flag` while `gate_en` is 1, and is 0 otherwise.
- R4: While the channel is on, the current-limit timer rises by one on each tick that has `lim_flag` set. On ticks with `lim_flag` clear it falls by one on every 128th such tick. The phase counter restarts on any tick with the flag set. The timer never goes below zero.
- R5: While the channel is on, the circuit-breaker timer rises by one on each tick that has `brk_flag` set, falls by one on each tick that has the flag clear, and never goes below zero.
- R6: The timeout inputs are 5-bit millisecond counts. The value 0 selects the default, which is 1 for `lim_tmo` and 3 for `brk_tmo`. The value 31 is clamped to 30. A timer expires when its count is at or above the resulting value.
- R7: On expiry, `gate_en` goes to 0 and `fault_n` goes to 0 on the clock after the timer reaches its timeout. In that first fault cycle `fast_pd` is 1, and only then.
- R8: With `retry_mode` = 0 a fault latches. `gate_en` stays 0 and `fault_n` stays 0 until shutdown (R1) or reset.
- R9: With `retry_mode` = 1 the channel cools down for 64 × (effective current-limit timeout) ticks with `fault_n` low. It then resumes with `gate_en` = 1 and `fault_n` = 1, or goes to the off state if power is not qualified at that moment.
- R10: Both timers and the cool-down count are held at zero whenever the channel is not on. Every turn-on therefore starts from empty timers.
- R11: While `rst` is high and on the clock after it, `gate_en` = 0, `fault_n` = 1, `fast_pd` = 0 and `reg_cmd` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_x | input | 1 | Enable X (OR-ed with Y) |
| en_y | input | 1 | Enable Y (OR-ed with X) |
| en_z | input | 1 | Enable Z (master) |
| supply_ok | input | 1 | Supply above undervoltage lockout |
| on_ok | input | 1 | Channel ON input above threshold |
| lim_flag | input | 1 | Current at or above the current-limit level |
| brk_flag | input | 1 | Current at or above the circuit-breaker level |
| ms_tick | input | 1 | One-cycle 1 kHz strobe |
| lim_tmo | input | 5 | Current-limit timeout, ms (0 = default) |
| brk_tmo | input | 5 | Circuit-breaker timeout, ms (0 = default) |
| retry_mode | input | 1 | 1 = automatic retry, 0 = latch off |
| gate_en | output | 1 | Gate enhancement command |
| fast_pd | output | 1 | One-cycle fast gate pulldown command |
| reg_cmd | output | 1 | Regulate gate to hold the current limit |
| fault_n | output | 1 | Active-low fault |

## Verification
The embedded properties watch several rules on every clock:
- Shutdown and loss of power qualification force the gate off on the next cycle.
- The fast-pulldown pulse never lasts more than one cycle and always coincides with a fault.
- Each timer steps up by exactly one on a charging tick and stays at zero on a discharging tick when empty.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared against the design on every clock:
- the 128-to-1 decay of the current-limit timer over long quiet stretches;
- the default and clamped timeout codes;
- latch release through shutdown;
- the length of the retry cool-down;
- fresh timers after each restart.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

    localparam int TMO_W    = 5;
    localparam int TMO_MIN  = 1;
    localparam int TMO_MAX  = 30;
    localparam int LIM_DFLT = 1;
    localparam int BRK_DFLT = 3;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ON    = 2'd1,
        CH_COOL  = 2'd2,
        CH_LATCH = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic gate_en;
        logic fast_pd;
        logic fault_n;
    } ch_cmd_t;

    // Map a raw timeout code to an effective timeout: 0 -> default, above range -> max.
    function automatic logic [TMO_W-1:0] eff_tmo(input logic [TMO_W-1:0] raw,
                                                 input logic [TMO_W-1:0] dflt);
        if (raw == '0)
            return dflt;
        else if (raw > TMO_W'(TMO_MAX))
            return TMO_W'(TMO_MAX);
        else if (raw < TMO_W'(TMO_MIN))
            return TMO_W'(TMO_MIN);
        else
            return raw;
    endfunction

endpackage

// File: rtl/oc_integ_timer.sv
module oc_integ_timer #(
    parameter int CNT_W     = 5,
    parameter int DECAY_DIV = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             flag,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             dec_en;

    generate
        if (DECAY_DIV > 1) begin : g_slow_decay
            localparam int PRE_W = $clog2(DECAY_DIV);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DECAY_DIV - 1);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || !run)
                    pre_q <= '0;
                else if (tick) begin
                    if (flag || pre_q == PRE_LAST)
                        pre_q <= '0;
                    else
                        pre_q <= pre_q + 1'b1;
                end
            end

            assign dec_en = tick && !flag && (pre_q == PRE_LAST);
        end else begin : g_fast_decay
            assign dec_en = tick && !flag;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick && flag) begin
            if (cnt_q != CNT_TOP)
                cnt_q <= cnt_q + 1'b1;
        end else if (dec_en && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q >= limit);

    // R4 / R5: a charging tick adds exactly one unit.
    assert_charge_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && tick && flag && cnt_q != CNT_TOP) |=> (!run || cnt_q == $past(cnt_q) + 1'b1));

    // R5 / R4: an empty timer stays empty on a discharging tick.
    assert_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !flag && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/oc_fault_seq.sv
module oc_fault_seq
    import oc_timer_pkg::*;
#(
    parameter int COOL_MULT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shut,
    input  logic             power_ok,
    input  logic             retry_mode,
    input  logic             tick,
    input  logic             expire_any,
    input  logic [TMO_W-1:0] cool_tmo,
    output ch_state_e        state,
    output logic             fast_pd
);
    localparam int COOL_W = $clog2(COOL_MULT * TMO_MAX + 1);

    ch_state_e        state_q, state_d;
    logic [COOL_W-1:0] cool_q;
    logic [COOL_W-1:0] cool_len;
    logic              cool_done;
    logic              go_fault;
    logic              pd_q;

    assign cool_len  = COOL_W'(COOL_MULT) * COOL_W'(cool_tmo);
    assign cool_done = (state_q == CH_COOL) && tick && (cool_q == cool_len - 1'b1);

    always_comb begin
        state_d  = state_q;
        go_fault = 1'b0;
        if (shut)
            state_d = CH_OFF;
        else begin
            unique case (state_q)
                CH_OFF:   if (power_ok) state_d = CH_ON;
                CH_ON: begin
                    if (!power_ok)
                        state_d = CH_OFF;
                    else if (expire_any) begin
                        go_fault = 1'b1;
                        state_d  = retry_mode ? CH_COOL : CH_LATCH;
                    end
                end
                CH_COOL:  if (cool_done) state_d = power_ok ? CH_ON : CH_OFF;
                CH_LATCH: state_d = CH_LATCH;
                default:  state_d = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_OFF;
            pd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pd_q    <= go_fault;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != CH_COOL)
            cool_q <= '0;
        else if (tick)
            cool_q <= cool_q + 1'b1;
    end

    assign state   = state_q;
    assign fast_pd = pd_q;

    // R8: a latched fault persists while no shutdown is requested.
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_LATCH && !shut) |=> (state_q == CH_LATCH));

endmodule

// File: rtl/oc_fault_timer.sv
module oc_fault_timer
    import oc_timer_pkg::*;
#(
    parameter int DECAY_DIV = 128,
    parameter int COOL_MULT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_x,
    input  logic             en_y,
    input  logic             en_z,
    input  logic             supply_ok,
    input  logic             on_ok,
    input  logic             lim_flag,
    input  logic             brk_flag,
    input  logic             ms_tick,
    input  logic [TMO_W-1:0] lim_tmo,
    input  logic [TMO_W-1:0] brk_tmo,
    input  logic             retry_mode,
    output logic             gate_en,
    output logic             fast_pd,
    output logic             reg_cmd,
    output logic             fault_n
);
    logic             shut_w;
    logic             pok_w;
    logic [TMO_W-1:0] lim_eff;
    logic [TMO_W-1:0] brk_eff;
    logic             lim_exp;
    logic             brk_exp;
    logic             run_w;
    ch_state_e        st;
    logic             pd_w;
    ch_cmd_t          cmd;

    assign shut_w  = !en_z || (!en_x && !en_y);
    assign pok_w   = supply_ok && on_ok;
    assign lim_eff = eff_tmo(lim_tmo, TMO_W'(LIM_DFLT));
    assign brk_eff = eff_tmo(brk_tmo, TMO_W'(BRK_DFLT));
    assign run_w   = (st == CH_ON);

    oc_integ_timer #(.CNT_W(TMO_W), .DECAY_DIV(DECAY_DIV)) u_lim_timer (
        .clk(clk), .rst(rst), .run(run_w), .tick(ms_tick),
        .flag(lim_flag), .limit(lim_eff), .expired(lim_exp)
    );

    oc_integ_timer #(.CNT_W(TMO_W), .DECAY_DIV(1)) u_brk_timer (
        .clk(clk), .rst(rst), .run(run_w), .tick(ms_tick),
        .flag(brk_flag), .limit(brk_eff), .expired(brk_exp)
    );

    oc_fault_seq #(.COOL_MULT(COOL_MULT)) u_seq (
        .clk(clk), .rst(rst), .shut(shut_w), .power_ok(pok_w),
        .retry_mode(retry_mode), .tick(ms_tick),
        .expire_any(lim_exp || brk_exp), .cool_tmo(lim_eff),
        .state(st), .fast_pd(pd_w)
    );

    always_comb begin
        cmd.gate_en = (st == CH_ON);
        cmd.fault_n = !(st == CH_COOL || st == CH_LATCH);
        cmd.fast_pd = pd_w;
    end

    assign gate_en = cmd.gate_en;
    assign fault_n = cmd.fault_n;
    assign fast_pd = cmd.fast_pd;
    assign reg_cmd = cmd.gate_en && lim_flag;

    assert_shutdown_off_R1: assert property (@(posedge clk) disable iff (rst)
        shut_w |=> (!gate_en && fault_n));

    assert_unqualified_off_R2: assert property (@(posedge clk) disable iff (rst)
        !pok_w |=> !gate_en);

    assert_pulse_in_fault_R7: assert property (@(posedge clk) disable iff (rst)
        fast_pd |-> (!fault_n && !gate_en));

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        fast_pd |=> !fast_pd);

endmodule

// File: tb/oc_fault_timer_bench.sv
module oc_fault_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_x = 0, en_y = 0, en_z = 0;
    logic       supply_ok = 0, on_ok = 0;
    logic       lim_flag = 0, brk_flag = 0;
    logic       ms_tick = 0;
    logic [4:0] lim_tmo = 5'd10, brk_tmo = 5'd10;
    logic       retry_mode = 0;
    logic       gate_en, fast_pd, reg_cmd, fault_n;

    int tests = 0;
    int fails = 0;
    string cur_req = "R11";

    oc_fault_timer u_oc_fault_timer (
        .clk(clk), .rst(rst), .en_x(en_x), .en_y(en_y), .en_z(en_z),
        .supply_ok(supply_ok), .on_ok(on_ok), .lim_flag(lim_flag),
        .brk_flag(brk_flag), .ms_tick(ms_tick), .lim_tmo(lim_tmo),
        .brk_tmo(brk_tmo), .retry_mode(retry_mode), .gate_en(gate_en),
        .fast_pd(fast_pd), .reg_cmd(reg_cmd), .fault_n(fault_n)
    );

    always #5 clk = ~clk;

    // 1 ms strobe, one cycle in five
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div == 4) ? 0 : tick_div + 1;
        ms_tick <= (tick_div == 4);
    end

    // Behavioural reference model (0 off, 1 on, 2 cooling, 3 latched)
    int ms = 0, cl = 0, clp = 0, cb = 0, cool = 0, pd = 0;
    always @(posedge clk) begin
        int eL, eB, nms, npd;
        bit shut, pok, ex, done;
        if (rst) begin
            ms = 0; cl = 0; clp = 0; cb = 0; cool = 0; pd = 0;
        end else begin
            eL = (lim_tmo == 0) ? 1 : ((lim_tmo > 30) ? 30 : int'(lim_tmo));
            eB = (brk_tmo == 0) ? 3 : ((brk_tmo > 30) ? 30 : int'(brk_tmo));
            shut = !en_z || (!en_x && !en_y);
            pok  = supply_ok && on_ok;
            ex   = (cl >= eL) || (cb >= eB);
            done = (ms == 2) && ms_tick && (cool == 64 * eL - 1);
            nms = ms; npd = 0;
            if (shut) nms = 0;
            else if (ms == 0) begin if (pok) nms = 1; end
            else if (ms == 1) begin
                if (!pok) nms = 0;
                else if (ex) begin npd = 1; nms = retry_mode ? 2 : 3; end
            end
            else if (ms == 2) begin if (done) nms = pok ? 1 : 0; end
            if (ms == 1) begin
                if (ms_tick) begin
                    if (lim_flag) begin if (cl < 31) cl++; clp = 0; end
                    else if (clp == 127) begin clp = 0; if (cl > 0) cl--; end
                    else clp++;
                    if (brk_flag) begin if (cb < 31) cb++; end
                    else if (cb > 0) cb--;
                end
            end else begin cl = 0; clp = 0; cb = 0; end
            if (ms == 2) begin if (ms_tick) cool++; end else cool = 0;
            ms = nms; pd = npd;
        end
        #2;
        tests++;
        if (gate_en !== (ms == 1) || fault_n !== !(ms == 2 || ms == 3) ||
            fast_pd !== (pd == 1) || reg_cmd !== ((ms == 1) && lim_flag)) begin
            fails++;
            $display("FAIL %s model: got gate=%b fault_n=%b pd=%b reg=%b exp gate=%b fault_n=%b pd=%b reg=%b",
                     cur_req, gate_en, fault_n, fast_pd, reg_cmd, ms == 1,
                     !(ms == 2 || ms == 3), pd == 1, (ms == 1) && lim_flag);
        end
    end

    task automatic chk(input string req, input logic got, input logic exp, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n * 5) @(negedge clk);
    endtask

    task automatic cycle_shutdown();
        en_z = 0; cyc(3);
        en_z = 1; cyc(3);
    endtask

    initial begin
        cyc(4);
        cur_req = "R11";
        chk("R11", gate_en, 1'b0, "gate in reset");
        chk("R11", fault_n, 1'b1, "fault_n in reset");
        chk("R11", fast_pd, 1'b0, "fast_pd in reset");
        rst = 0; cyc(2);
        chk("R11", reg_cmd, 1'b0, "reg after reset");

        cur_req = "R2";
        en_z = 1; en_x = 1; supply_ok = 1; on_ok = 1; cyc(3);
        chk("R2", gate_en, 1'b1, "turn-on");

        cur_req = "R3";
        lim_flag = 1; cyc(2);
        chk("R3", reg_cmd, 1'b1, "regulate follows flag");
        lim_flag = 0; cyc(2);
        chk("R3", reg_cmd, 1'b0, "regulate released");

        cur_req = "R1";
        en_x = 0; en_y = 1; cyc(3);
        chk("R1", gate_en, 1'b1, "one of X/Y low ignored");
        en_y = 0; cyc(3);
        chk("R1", gate_en, 1'b0, "X and Y low shuts down");
        chk("R1", fault_n, 1'b1, "shutdown no fault");
        en_x = 1; cyc(3);

        cur_req = "R2";
        supply_ok = 0; cyc(3);
        chk("R2", gate_en, 1'b0, "UVLO off");
        chk("R2", fault_n, 1'b1, "UVLO no fault");
        supply_ok = 1; cyc(3);
        chk("R2", gate_en, 1'b1, "UVLO recovery");

        // R4: slow decay, latch mode
        cur_req = "R4";
        lim_tmo = 5'd5; retry_mode = 0;
        lim_flag = 1; ticks(4); lim_flag = 0;
        ticks(100);
        lim_flag = 1; ticks(1); lim_flag = 0; cyc(3);
        chk("R4", fault_n, 1'b0, "no decay within 128 ticks");
        cur_req = "R8";
        ticks(20);
        chk("R8", gate_en, 1'b0, "latched gate");
        chk("R8", fault_n, 1'b0, "latched fault");
        cycle_shutdown();
        chk("R8", gate_en, 1'b1, "latch cleared by shutdown");
        chk("R8", fault_n, 1'b1, "fault cleared by shutdown");

        cur_req = "R4";
        lim_flag = 1; ticks(4); lim_flag = 0;
        ticks(140);
        lim_flag = 1; ticks(1); lim_flag = 0; cyc(3);
        chk("R4", gate_en, 1'b1, "one unit decayed");

        cur_req = "R10";
        cycle_shutdown();
        lim_flag = 1; ticks(4); lim_flag = 0; cyc(3);
        chk("R10", gate_en, 1'b1, "timer fresh after restart");
        cycle_shutdown();

        // R5: symmetric breaker timer, then retry
        cur_req = "R5";
        brk_tmo = 5'd4; retry_mode = 1;
        brk_flag = 1; ticks(3); brk_flag = 0; ticks(3);
        brk_flag = 1; ticks(3); brk_flag = 0; cyc(3);
        chk("R5", gate_en, 1'b1, "breaker decays per tick");
        ticks(10);
        cur_req = "R7";
        brk_flag = 1; ticks(4); brk_flag = 0; cyc(3);
        chk("R7", gate_en, 1'b0, "breaker fault gate");
        chk("R7", fault_n, 1'b0, "breaker fault output");
        cur_req = "R9";
        ticks(100);
        chk("R9", fault_n, 1'b0, "still cooling");
        ticks(240);
        chk("R9", gate_en, 1'b1, "retry restart");
        chk("R9", fault_n, 1'b1, "retry fault released");

        // R6: clamp and defaults
        cur_req = "R6";
        retry_mode = 0; brk_tmo = 5'd31;
        cycle_shutdown();
        brk_flag = 1; ticks(29); cyc(3);
        chk("R6", gate_en, 1'b1, "31 clamps to 30");
        ticks(1); brk_flag = 0; cyc(3);
        chk("R6", fault_n, 1'b0, "fault at 30");
        cycle_shutdown();
        lim_tmo = 5'd0;
        lim_flag = 1; ticks(1); lim_flag = 0; cyc(3);
        chk("R6", fault_n, 1'b0, "lim default 1");
        cycle_shutdown();
        brk_tmo = 5'd0;
        brk_flag = 1; ticks(2); brk_flag = 0; cyc(3);
        chk("R6", gate_en, 1'b1, "brk default 3 not yet");
        ticks(2);
        brk_flag = 1; ticks(3); brk_flag = 0; cyc(3);
        chk("R6", fault_n, 1'b0, "brk default 3 reached");

        // R9 with default cool-down of 64 ticks
        cur_req = "R9";
        retry_mode = 1;
        cycle_shutdown();
        lim_flag = 1; ticks(1); lim_flag = 0;
        ticks(70);
        chk("R9", gate_en, 1'b1, "64-tick cool-down done");

        cyc(5);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule